// File: doc/BRIEF.md
# Tagged Display Init Sequencer

This block brings up a display controller after reset by stepping through a fixed list of 16-bit entries held in an internal ROM. The upper byte of each entry selects an action and the lower byte is its argument. An entry can clock one command byte out on a write-only serial link, clock one data byte out, or hold the link idle for a number of milliseconds. A command may be followed by any number of data entries, including none. A separate line tells the controller whether the current byte is a command or a parameter.

A host pulses `start`. The block then pulls chip select low once, works through every entry in order, releases chip select after the last entry and pulses `done`. The serial clock runs at a quarter of the system clock. The length of one millisecond is a parameter counted in system clocks, so a simulation can use a short value. The ROM contents are a parameter. The default list opens with a reset command and a 5 ms pause. Further down it has sleep-exit, a 10 ms pause and display-on.

The controller has six named states. IDLE moves to LOAD when start is high. LOAD decodes the entry at the pointer. A data or command entry goes to SEND. A pause with a non-zero argument goes to WAIT. Any other entry advances the pointer: to CLOSE after the last entry, otherwise back to LOAD. SEND returns by the same advance rule after the byte's final serial clock cycle. WAIT returns by the same rule when the pause expires. CLOSE releases chip select and moves to DONE. DONE drops busy, pulses done and returns to IDLE.

Top module: `disp_init_seq`

## Requirements
- R1: An entry whose bits 15:8 equal 0x00 is a data entry. It drives `lcd_dc` high and sends bits 7:0 as one byte.
- R2: An entry whose bits 15:8 equal 0x01 is a command entry. It drives `lcd_dc` low and sends bits 7:0 as one byte. Any number of data entries, including none, may follow a command.
- R3: An entry whose bits 15:8 equal 0x02 holds the link idle for exactly arg × MS_CYCLES clocks after its decode cycle, with `spi_sck` and `spi_mosi` low. An argument of 0 adds no wait.
- R4: An entry with any other type code is skipped. It takes only its decode cycle, produces no serial clock or data activity, and leaves `lcd_dc` unchanged.
- R5: `lcd_cs_n` goes low in the cycle after start is accepted and stays low through every entry. It goes high two cycles after the last entry ends, one cycle after the CLOSE cycle.
- R6: The link uses SPI mode 0, MSB first, with SCK at clk/4. Each bit lasts 4 clocks: SCK is low for 2 clocks, then high for 2 clocks. `spi_mosi` changes only while SCK is low. SCK idles low.
- R7: `lcd_dc` takes its new value before the first rising SCK edge of a byte, at least one clock earlier, and holds that value while the byte is sent.
- R8: `busy` rises in the cycle after `start` is sampled high in IDLE. A `start` that arrives while busy is ignored.
- R9: `done` is high for exactly one cycle, the cycle after chip select is released. `busy` falls in that same cycle.
- R10: Each entry begins with one decode cycle with no SCK activity. A byte entry then takes 32 clocks.
- R11: The default list begins with command 0x01 followed by a 5 ms pause. It later contains command 0x11, a 10 ms pause and command 0x29, in that order.
- R12: The parameter MS_CYCLES sets how many clocks make one millisecond of pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the list; sampled only while idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the run completes |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_dc | output | 1 | High for a data byte, low for a command byte |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, MSB first |

## Verification
The default list is replayed against a second list. The second list has a command with no data after it, an unknown type placed right after a command, a zero-length pause, a short pause and back-to-back data bytes. A mismatch therefore separates a decoding fault, a dc-hold fault, a skip fault and a delay-length fault. The run uses two pause scales (20 and 3 clocks per millisecond), which exposes a timer that ignores MS_CYCLES. The default run holds start high for several cycles after it is accepted, and the second list runs twice, which separates an ignored restart from a false one and checks that dc carries over between runs. Byte values with alternating and repeated bits show bit order and shift timing.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

    localparam logic [7:0] KIND_DATA = 8'h00;
    localparam logic [7:0] KIND_CMD  = 8'h01;
    localparam logic [7:0] KIND_WAIT = 8'h02;

    typedef struct packed {
        logic [7:0] kind;
        logic [7:0] arg;
    } entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SEND,
        S_WAIT,
        S_CLOSE,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/dinit_rom.sv
module dinit_rom
    import dinit_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned AW        = 4,
    parameter logic [15:0] LIST [N_ENTRIES] = '{default: 16'h0000}
) (
    input  logic [AW-1:0] addr,
    output entry_t        word
);

    // Read is combinational; addresses past the end return a zero entry.
    always_comb begin
        word = '0;
        for (int i = 0; i < int'(N_ENTRIES); i++) begin
            if (addr == AW'(i)) begin
                word = entry_t'(LIST[i]);
            end
        end
    end

endmodule

// File: rtl/dinit_shift.sv
module dinit_shift #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] din,
    output logic            sck,
    output logic            mosi,
    output logic            active,
    output logic            last
);

    // Four system clocks per bit: two with SCK low, two with SCK high.
    localparam int unsigned TICKS = BITS * 4;
    localparam int unsigned CW    = $clog2(TICKS);
    localparam logic [CW-1:0] CNT_END = CW'(TICKS - 1);

    logic [CW-1:0]   cnt;
    logic [BITS-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sreg   <= '0;
            active <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            sreg   <= din;
            active <= 1'b1;
        end else if (active) begin
            cnt <= cnt + 1'b1;
            if (cnt[1:0] == 2'b11) begin
                sreg <= {sreg[BITS-2:0], 1'b0};
            end
            if (cnt == CNT_END) begin
                active <= 1'b0;
            end
        end
    end

    assign sck  = active & cnt[1];
    assign mosi = active & sreg[BITS-1];
    assign last = active && (cnt == CNT_END);

    // R6: each high phase of SCK is preceded by two low cycles
    a_r6_sck_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> !$past(sck, 2));

    // R6: data line is steady while SCK is high
    a_r6_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/dinit_timer.sv
module dinit_timer #(
    parameter int unsigned MS_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] ms,
    output logic       running,
    output logic       expire
);

    localparam int unsigned SW = $clog2(MS_CYCLES + 1);
    localparam logic [SW-1:0] SUB_END = SW'(MS_CYCLES - 1);

    logic [SW-1:0] sub;
    logic [7:0]    left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub     <= '0;
            left    <= '0;
            running <= 1'b0;
        end else if (load) begin
            sub     <= '0;
            left    <= ms;
            running <= (ms != 8'd0);
        end else if (running) begin
            if (sub == SUB_END) begin
                sub  <= '0;
                left <= left - 8'd1;
                if (left == 8'd1) begin
                    running <= 1'b0;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign expire = running && (sub == SUB_END) && (left == 8'd1);

    // R3: an active pause always has at least one millisecond left
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (left != 8'd0));

endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq
    import dinit_pkg::*;
#(
    parameter int unsigned MS_CYCLES = 50000,
    parameter int unsigned N_ENTRIES = 16,
    parameter logic [15:0] INIT_LIST [N_ENTRIES] = '{
        16'h0101, 16'h0205, 16'h0128, 16'h01B1,
        16'h0000, 16'h001B, 16'h01C0, 16'h0010,
        16'h0136, 16'h00C8, 16'h013A, 16'h0055,
        16'h0111, 16'h020A, 16'h0129, 16'h012C
    }
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic lcd_cs_n,
    output logic lcd_dc,
    output logic spi_sck,
    output logic spi_mosi
);

    localparam int unsigned PW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PW-1:0] PTR_END = PW'(N_ENTRIES - 1);

    seq_state_t    st, nx;
    logic [PW-1:0] ptr;
    entry_t        cur;
    logic          is_last, is_byte, is_pause, step;
    logic          tx_load, tx_last, tx_active;
    logic          tm_load, tm_exp, tm_running;

    dinit_rom #(
        .N_ENTRIES (N_ENTRIES),
        .AW        (PW),
        .LIST      (INIT_LIST)
    ) u_rom (
        .addr (ptr),
        .word (cur)
    );

    dinit_shift #(
        .BITS (8)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tx_load),
        .din    (cur.arg),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .active (tx_active),
        .last   (tx_last)
    );

    dinit_timer #(
        .MS_CYCLES (MS_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tm_load),
        .ms      (cur.arg),
        .running (tm_running),
        .expire  (tm_exp)
    );

    assign is_last  = (ptr == PTR_END);
    assign is_byte  = (cur.kind == KIND_DATA) || (cur.kind == KIND_CMD);
    assign is_pause = (cur.kind == KIND_WAIT) && (cur.arg != 8'd0);
    assign tx_load  = (st == S_LOAD) && is_byte;
    assign tm_load  = (st == S_LOAD) && (cur.kind == KIND_WAIT);

    // Next-state decode
    always_comb begin
        nx   = st;
        step = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (start) nx = S_LOAD;
            end
            S_LOAD: begin
                if (is_byte) begin
                    nx = S_SEND;
                end else if (is_pause) begin
                    nx = S_WAIT;
                end else begin
                    step = 1'b1;
                    nx   = is_last ? S_CLOSE : S_LOAD;
                end
            end
            S_SEND: begin
                if (tx_last) begin
                    step = 1'b1;
                    nx   = is_last ? S_CLOSE : S_LOAD;
                end
            end
            S_WAIT: begin
                if (tm_exp) begin
                    step = 1'b1;
                    nx   = is_last ? S_CLOSE : S_LOAD;
                end
            end
            S_CLOSE: nx = S_DONE;
            S_DONE:  nx = S_IDLE;
            default: nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // Registered outputs and list pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            lcd_cs_n <= 1'b1;
            lcd_dc   <= 1'b1;
            ptr      <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        busy     <= 1'b1;
                        lcd_cs_n <= 1'b0;
                        ptr      <= '0;
                    end
                end
                S_LOAD: begin
                    if (cur.kind == KIND_DATA) lcd_dc <= 1'b1;
                    else if (cur.kind == KIND_CMD) lcd_dc <= 1'b0;
                end
                S_CLOSE: lcd_cs_n <= 1'b1;
                S_DONE: begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                default: ;
            endcase
            if (step && !is_last) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // R5: chip select is only low inside a run
    a_r5_cs_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs_n |-> busy);

    // R6: no serial clock outside the chip-select window
    a_r6_sck_selected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !lcd_cs_n);

    // R7: dc holds while a byte is on the wire
    a_r7_dc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SEND && $past(st == S_SEND)) |-> $stable(lcd_dc));

    // R3: link stays quiet during a pause
    a_r3_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT) |-> (!spi_sck && !spi_mosi && tm_running));

    // R4 and R10: decode cycle has no serial activity
    a_r4_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOAD) |-> (!tx_active && !spi_sck));

    // R8: busy only rises after a start request
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9: done is a single pulse after chip select is released
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lcd_cs_n && $past(lcd_cs_n) && !busy));

endmodule

// File: tb/disp_init_seq_test.sv
module disp_init_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0;
    logic start1 = 1'b0;
    int   total = 0;
    int   bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    logic busy0, done0, cs0, dc0, sck0, mosi0;
    logic busy1, done1, cs1, dc1, sck1, mosi1;

    localparam int MS0 = 20;
    localparam int MS1 = 3;

    // Same list the default design carries (R11 names its key entries)
    logic [15:0] def_list [16] = '{
        16'h0101, 16'h0205, 16'h0128, 16'h01B1,
        16'h0000, 16'h001B, 16'h01C0, 16'h0010,
        16'h0136, 16'h00C8, 16'h013A, 16'h0055,
        16'h0111, 16'h020A, 16'h0129, 16'h012C
    };
    localparam logic [15:0] ALT_LIST [9] = '{
        16'h0155, 16'h05AA, 16'h01A3, 16'h003C, 16'h00F0,
        16'h0200, 16'h0203, 16'h0081, 16'h0142
    };

    disp_init_seq #(.MS_CYCLES(MS0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start0),
        .busy(busy0), .done(done0), .lcd_cs_n(cs0), .lcd_dc(dc0),
        .spi_sck(sck0), .spi_mosi(mosi0)
    );

    disp_init_seq #(.MS_CYCLES(MS1), .N_ENTRIES(9), .INIT_LIST(ALT_LIST)) uut_alt (
        .clk(clk), .rst_n(rst_n), .start(start1),
        .busy(busy1), .done(done1), .lcd_cs_n(cs1), .lcd_dc(dc1),
        .spi_sck(sck1), .spi_mosi(mosi1)
    );

    // Expected per-cycle outputs {cs_n, dc, sck, mosi, busy, done}
    logic [5:0] eq[$];
    string      tq[$];
    bit         dc_model [2] = '{1'b1, 1'b1};

    function automatic void push(bit cs, bit dc, bit sk, bit mo, bit by, bit dn, string t);
        eq.push_back({cs, dc, sk, mo, by, dn});
        tq.push_back(t);
    endfunction

    function automatic logic [5:0] observe(int which);
        if (which == 0) return {cs0, dc0, sck0, mosi0, busy0, done0};
        return {cs1, dc1, sck1, mosi1, busy1, done1};
    endfunction

    task automatic check(logic [5:0] got, logic [5:0] exp, string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (cs_n dc sck mosi busy done) at %0t",
                     tag, got, exp, $time);
        end
    endtask

    // Behavioural reference: expand the list into a cycle trace
    task automatic build(int which);
        int n  = (which == 0) ? 16 : 9;
        int ms = (which == 0) ? MS0 : MS1;
        bit d  = dc_model[which];
        for (int i = 0; i < n; i++) begin
            logic [15:0] e = (which == 0) ? def_list[i] : ALT_LIST[i];
            logic [7:0]  k = e[15:8];
            logic [7:0]  p = e[7:0];
            string head = (which == 0 && i < 2) ? "R11" : "R10";
            push(0, d, 0, 0, 1, 0, head);                 // decode cycle
            if (k == 8'h00 || k == 8'h01) begin
                d = (k == 8'h00);                          // R1 / R2
                for (int c = 0; c < 32; c++) begin
                    string t = (c < 2) ? "R7" : ((k == 8'h00) ? "R1/R6" : "R2/R6");
                    push(0, d, (c >> 1) & 1, p[7 - c / 4], 1, 0, t);
                end
            end else if (k == 8'h02) begin
                for (int c = 0; c < int'(p) * ms; c++)
                    push(0, d, 0, 0, 1, 0, (which == 0) ? "R3" : "R12");
            end
            // other kinds: decode cycle only (R4)
        end
        push(0, d, 0, 0, 1, 0, "R5");   // close cycle
        push(1, d, 0, 0, 1, 0, "R5");   // released
        push(1, d, 0, 0, 0, 1, "R9");   // done pulse
        push(1, d, 0, 0, 0, 0, "R9");   // back to idle
        dc_model[which] = d;
    endtask

    task automatic run(int which, int hold);
        eq.delete();
        tq.delete();
        build(which);
        @(negedge clk);
        if (which == 0) start0 = 1'b1; else start1 = 1'b1;
        for (int i = 0; i < eq.size(); i++) begin
            @(negedge clk);
            // R8: start kept high while busy must not restart the run
            if (which == 0) start0 = (i + 1 < hold); else start1 = (i + 1 < hold);
            check(observe(which), eq[i], tq[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state: cs high, dc high, link idle, not busy
        check(observe(0), 6'b110000, "R5");
        check(observe(1), 6'b110000, "R5");
        run(0, 12);     // default list, start held while busy (R8, R11, R3)
        run(1, 1);      // alt list: bare command, unknown kind, zero pause (R4, R12)
        repeat (4) @(negedge clk);
        check(observe(1), {1'b1, dc_model[1], 4'b0000}, "R8");
        run(1, 3);      // rerun, dc carried from previous run
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule